// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Bus Monitor

This block passively watches a three-wire, half-duplex synchronous serial bus made of an active-high select, a serial clock, a controller-to-target data line and a target-to-controller data line. A fast system clock oversamples all four lines. The block never drives the bus. While the target is selected it turns clock activity into bit records. Each record carries the input-line value taken at a clock rising edge, the output-line value taken at the next falling edge, and timestamps from a free-running counter for the bit's start and end. The first record of a window is marked as the start bit.

Some select windows are ready/busy polls and carry no bit transfers. A window is a poll if the clock never rises, or if the input line is low at the first clock rise. The poll result is only known once one of those conditions is seen. For that reason, ready/busy intervals seen on the output line go into a small record buffer. If the window turns out to be a data transfer, the buffer is discarded. If the window ends as a poll, the buffer is replayed after the select drops, followed by the final interval. Warnings flag a select that opens while the clock is high and a buffer that ran out of room.

Top module: `mw_monitor`

## Requirements
- R1: A rising edge on `cs_i` (select is active high) opens a window. If `sk_i` is high at that moment, a one-cycle warning with code 1 is raised. The next clock falling edge is then ignored, so the first bit begins at the following real rising edge.
- R2: In a data window, the input line is sampled at each clock rise and the output line at each clock fall. A bit record is emitted at the next clock rise. Its start and end timestamps are the two rising-edge times, so end minus start equals the rise-to-rise spacing in system cycles.
- R3: The first record of a data window has `bit_first_o` = 1 and carries the start bit. Every later record of that window has `bit_first_o` = 0.
- R4: A select fall while the clock is low closes the open bit, and its end timestamp is the select-fall time. A select fall while the clock is high drops the open bit.
- R5: A window is a status poll when no clock rise occurs, or when the input line is 0 at the first clock rise. A status poll emits no bit records.
- R6: In a status poll, every change of the output line closes the current interval. The interval is reported with `st_ready_o` = 1 for ready (line high) or 0 for busy (line low), plus its start and end timestamps. The final interval ends at the select fall. Records come out in time order, each one starting where the previous one ended.
- R7: Status intervals are held in a DEPTH-entry buffer until the select falls. They are discarded when the first clock rise shows input high, so a data window emits no status records.
- R8: When the buffer is full, further intervals are dropped and warning code 2 pulses once per window. The final interval is still reported.
- R9: `bit_valid_o` and `warn_valid_o` are single-cycle strobes, and every record has an end timestamp later than its start.
- R10: After reset, all strobes are low and the monitor waits for a select rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Bus select line, active high |
| sk_i | input | 1 | Bus serial clock |
| si_i | input | 1 | Controller-to-target data line |
| so_i | input | 1 | Target-to-controller data line |
| bit_valid_o | output | 1 | Bit record strobe |
| bit_first_o | output | 1 | Record is the start bit |
| bit_si_o | output | 1 | Input-line value of the bit |
| bit_so_o | output | 1 | Output-line value of the bit |
| bit_t0_o | output | TS_W | Bit start timestamp |
| bit_t1_o | output | TS_W | Bit end timestamp |
| st_valid_o | output | 1 | Status interval strobe |
| st_ready_o | output | 1 | 1 ready, 0 busy |
| st_t0_o | output | TS_W | Interval start timestamp |
| st_t1_o | output | TS_W | Interval end timestamp |
| warn_valid_o | output | 1 | Warning strobe |
| warn_code_o | output | 2 | 1 clock high at select, 2 buffer overflow |

## Verification
The hardest case to reach is a window whose classification arrives late. The output line must toggle several times before any clock edge, so that interval records pile up in the buffer. Only then does the first clock rise decide whether they are replayed or thrown away. The stimulus toggles the output line with the clock held still: past the buffer depth to force the overflow warning, and in another window just twice before a rise with the input high, to show that the pending records are discarded.

// File: rtl/mw_mon_pkg.sv
`timescale 1ns/1ps
package mw_mon_pkg;
  localparam int CS_IX = 0;
  localparam int SK_IX = 1;
  localparam int SI_IX = 2;
  localparam int SO_IX = 3;
  localparam int LINES = 4;

  typedef enum logic [1:0] {
    WARN_NONE     = 2'd0,
    WARN_SK_HIGH  = 2'd1,
    WARN_OVERFLOW = 2'd2
  } warn_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    WIN_OPEN   = 2'd0,
    WIN_DATA   = 2'd1,
    WIN_STATUS = 2'd2
  } win_e;
endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl_o[g]  = sync_q;
    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/mw_recbuf.sv
`timescale 1ns/1ps
module mw_recbuf #(
  parameter int W     = 65,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wen, ren;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wen     = push_i && !full_o;
  assign ren     = pop_i && !empty_o;
  assign dout_o  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (wen) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (ren) rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      if (wen && !ren) cnt_d = cnt_q + CW'(1);
      else if (ren && !wen) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wen && !flush_i) mem[wr_q] <= din_i;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R7
  flush_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !push_i);
endmodule

// File: rtl/mw_monitor.sv
`timescale 1ns/1ps
module mw_monitor
  import mw_mon_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_i,
  input  logic            sk_i,
  input  logic            si_i,
  input  logic            so_i,
  output logic            bit_valid_o,
  output logic            bit_first_o,
  output logic            bit_si_o,
  output logic            bit_so_o,
  output logic [TS_W-1:0] bit_t0_o,
  output logic [TS_W-1:0] bit_t1_o,
  output logic            st_valid_o,
  output logic            st_ready_o,
  output logic [TS_W-1:0] st_t0_o,
  output logic [TS_W-1:0] st_t1_o,
  output logic            warn_valid_o,
  output logic [1:0]      warn_code_o
);
  localparam int REC_W = 1 + 2 * TS_W;

  logic [LINES-1:0] lvl, rise, fall;
  logic [REC_W-1:0] rec_in, rec_out;
  logic             push, pop, flush, buf_empty, buf_full;

  mw_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({so_i, si_i, sk_i, cs_i}),
    .lvl_o (lvl), .rise_o(rise), .fall_o(fall)
  );

  mw_recbuf #(.W(REC_W), .DEPTH(DEPTH)) u_buf (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .flush_i(flush), .push_i(push), .din_i(rec_in),
    .pop_i (pop), .dout_o(rec_out),
    .empty_o(buf_empty), .full_o(buf_full)
  );

  logic unused_lines;
  assign unused_lines = ^{lvl[CS_IX], rise[SI_IX], fall[SI_IX]};

  state_e           state_q, state_d;
  win_e             win_q, win_d;
  logic [TS_W-1:0]  ts_q;
  logic             bopen_q, bopen_d, bsi_q, bsi_d, bso_q, bso_d, first_q, first_d;
  logic [TS_W-1:0]  bt0_q, bt0_d;
  logic             slvl_q, slvl_d, ovf_q, ovf_d;
  logic [TS_W-1:0]  st0_q, st0_d;
  logic             frdy_q, frdy_d;
  logic [TS_W-1:0]  ft0_q, ft0_d, ft1_q, ft1_d;
  logic             bv_q, bv_d, bf_q, bf_d, obsi_q, obsi_d, obso_q, obso_d;
  logic [TS_W-1:0]  obt0_q, obt0_d, obt1_q, obt1_d;
  logic             sv_q, sv_d, srdy_q, srdy_d;
  logic [TS_W-1:0]  ost0_q, ost0_d, ost1_q, ost1_d;
  logic             wv_q, wv_d;
  warn_e            wc_q, wc_d;

  assign rec_in = {slvl_q, st0_q, ts_q};

  always_comb begin
    state_d = state_q;  win_d  = win_q;
    bopen_d = bopen_q;  bt0_d  = bt0_q;  bsi_d = bsi_q;  bso_d = bso_q;
    first_d = first_q;  slvl_d = slvl_q; st0_d = st0_q;  ovf_d = ovf_q;
    frdy_d  = frdy_q;   ft0_d  = ft0_q;  ft1_d = ft1_q;
    bv_d = 1'b0; bf_d = bf_q; obsi_d = obsi_q; obso_d = obso_q;
    obt0_d = obt0_q; obt1_d = obt1_q;
    sv_d = 1'b0; srdy_d = srdy_q; ost0_d = ost0_q; ost1_d = ost1_q;
    wv_d = 1'b0; wc_d = wc_q;
    push = 1'b0; pop = 1'b0; flush = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rise[CS_IX]) begin
          state_d = ST_ACTIVE;
          win_d   = WIN_OPEN;
          bopen_d = 1'b0;
          first_d = 1'b1;
          ovf_d   = 1'b0;
          slvl_d  = lvl[SO_IX];
          st0_d   = ts_q;
          flush   = 1'b1;
          if (lvl[SK_IX]) begin
            wv_d = 1'b1;
            wc_d = WARN_SK_HIGH;
          end
        end
      end
      ST_ACTIVE: begin
        if (fall[CS_IX]) begin
          if (win_q == WIN_DATA) begin
            if (bopen_q && !lvl[SK_IX]) begin
              bv_d = 1'b1; bf_d = first_q; obsi_d = bsi_q; obso_d = bso_q;
              obt0_d = bt0_q; obt1_d = ts_q;
            end
            bopen_d = 1'b0;
            state_d = ST_IDLE;
          end else begin
            frdy_d  = slvl_q;
            ft0_d   = st0_q;
            ft1_d   = ts_q;
            state_d = ST_DRAIN;
          end
        end else begin
          if (rise[SK_IX]) begin
            if (win_q == WIN_OPEN) begin
              if (lvl[SI_IX]) begin
                win_d = WIN_DATA;
                flush = 1'b1;
              end else begin
                win_d = WIN_STATUS;
              end
            end else if (win_q == WIN_DATA && bopen_q) begin
              bv_d = 1'b1; bf_d = first_q; obsi_d = bsi_q; obso_d = bso_q;
              obt0_d = bt0_q; obt1_d = ts_q;
              first_d = 1'b0;
            end
            if (win_d == WIN_DATA) begin
              bopen_d = 1'b1;
              bt0_d   = ts_q;
              bsi_d   = lvl[SI_IX];
            end
          end
          if (fall[SK_IX]) bso_d = lvl[SO_IX];
          if ((rise[SO_IX] || fall[SO_IX]) && win_d != WIN_DATA) begin
            if (!buf_full) begin
              push = 1'b1;
            end else if (!ovf_q) begin
              wv_d  = 1'b1;
              wc_d  = WARN_OVERFLOW;
              ovf_d = 1'b1;
            end
            st0_d  = ts_q;
            slvl_d = lvl[SO_IX];
          end
        end
      end
      ST_DRAIN: begin
        sv_d = 1'b1;
        if (!buf_empty) begin
          pop    = 1'b1;
          srdy_d = rec_out[REC_W-1];
          ost0_d = rec_out[2*TS_W-1:TS_W];
          ost1_d = rec_out[TS_W-1:0];
        end else begin
          srdy_d  = frdy_q;
          ost0_d  = ft0_q;
          ost1_d  = ft1_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; win_q <= WIN_OPEN; ts_q <= '0;
      bopen_q <= 1'b0; bt0_q <= '0; bsi_q <= 1'b0; bso_q <= 1'b0; first_q <= 1'b1;
      slvl_q <= 1'b0; st0_q <= '0; ovf_q <= 1'b0;
      frdy_q <= 1'b0; ft0_q <= '0; ft1_q <= '0;
      bv_q <= 1'b0; bf_q <= 1'b0; obsi_q <= 1'b0; obso_q <= 1'b0;
      obt0_q <= '0; obt1_q <= '0;
      sv_q <= 1'b0; srdy_q <= 1'b0; ost0_q <= '0; ost1_q <= '0;
      wv_q <= 1'b0; wc_q <= WARN_NONE;
    end else begin
      state_q <= state_d; win_q <= win_d; ts_q <= ts_q + TS_W'(1);
      bopen_q <= bopen_d; bt0_q <= bt0_d; bsi_q <= bsi_d; bso_q <= bso_d; first_q <= first_d;
      slvl_q <= slvl_d; st0_q <= st0_d; ovf_q <= ovf_d;
      frdy_q <= frdy_d; ft0_q <= ft0_d; ft1_q <= ft1_d;
      bv_q <= bv_d; bf_q <= bf_d; obsi_q <= obsi_d; obso_q <= obso_d;
      obt0_q <= obt0_d; obt1_q <= obt1_d;
      sv_q <= sv_d; srdy_q <= srdy_d; ost0_q <= ost0_d; ost1_q <= ost1_d;
      wv_q <= wv_d; wc_q <= wc_d;
    end
  end

  assign bit_valid_o  = bv_q;
  assign bit_first_o  = bf_q;
  assign bit_si_o     = obsi_q;
  assign bit_so_o     = obso_q;
  assign bit_t0_o     = obt0_q;
  assign bit_t1_o     = obt1_q;
  assign st_valid_o   = sv_q;
  assign st_ready_o   = srdy_q;
  assign st_t0_o      = ost0_q;
  assign st_t1_o      = ost1_q;
  assign warn_valid_o = wv_q;
  assign warn_code_o  = wc_q;

  // R9
  bit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
  // R9
  warn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_valid_o |=> !warn_valid_o);
  // R2
  bit_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (bit_t1_o > bit_t0_o));
  // R6
  st_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |-> (st_t1_o > st_t0_o));
  // R5
  no_bits_in_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == WIN_STATUS) |-> !bit_valid_o);
  // R7
  data_buf_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && win_q == WIN_DATA) |-> buf_empty);
  // R1
  sk_warn_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_valid_o && warn_code_o == 2'd1) |-> (state_q == ST_ACTIVE));
endmodule

// File: tb/sim_mw_monitor.sv
`timescale 1ns/1ps
module sim_mw_monitor;
  localparam int TS_W  = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;
  logic bv, bf, bsi, bso, sv, srdy, wv;
  logic [TS_W-1:0] bt0, bt1, st0, st1;
  logic [1:0] wc;

  always #10 clk = ~clk;

  mw_monitor #(.TS_W(TS_W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .si_i(si), .so_i(so),
    .bit_valid_o(bv), .bit_first_o(bf), .bit_si_o(bsi), .bit_so_o(bso),
    .bit_t0_o(bt0), .bit_t1_o(bt1),
    .st_valid_o(sv), .st_ready_o(srdy), .st_t0_o(st0), .st_t1_o(st1),
    .warn_valid_o(wv), .warn_code_o(wc)
  );

  int n_chk = 0, n_fail = 0;
  int nb = 0, ns = 0, nw = 0;
  int b_si[32], b_so[32], b_first[32];
  longint b_dur[32];
  int s_rdy[32];
  longint s_t0[32], s_t1[32];
  int w_code[32];
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bv && nb < 32) begin
        b_si[nb] = bsi; b_so[nb] = bso; b_first[nb] = bf;
        b_dur[nb] = longint'(bt1) - longint'(bt0); nb++;
      end
      if (sv && ns < 32) begin
        s_rdy[ns] = srdy; s_t0[ns] = st0; s_t1[ns] = st1; ns++;
      end
      if (wv && nw < 32) begin
        w_code[nw] = wc; nw++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    nb = 0; ns = 0; nw = 0;
  endtask

  task automatic send_bit(input logic si_v, input logic so_v);
    si = si_v; wait_n(4);
    sk = 1'b1; so = so_v; wait_n(8);
    sk = 1'b0; wait_n(4);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset();
    wait_n(10);
    chk_eq("R10 no bit strobe after reset", nb, 0);
    chk_eq("R10 no status strobe after reset", ns, 0);
    chk_eq("R10 no warning after reset", nw, 0);
  endtask

  task automatic t_data();
    clear_log();
    cs = 1'b1; wait_n(8);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    cs = 1'b0; wait_n(12);
    chk_eq("R2 bit count", nb, 4);
    chk_eq("R3 first flag on start bit", b_first[0], 1);
    chk_eq("R3 first flag clear later", b_first[1] + b_first[2] + b_first[3], 0);
    chk_eq("R2 si pattern", b_si[0]*8 + b_si[1]*4 + b_si[2]*2 + b_si[3], 11);
    chk_eq("R2 so pattern", b_so[0]*8 + b_so[1]*4 + b_so[2]*2 + b_so[3], 6);
    chk_eq("R2 rise-to-rise span", b_dur[1], 16);
    chk_eq("R4 final bit ends at select fall", b_dur[3], 12);
    chk_eq("R7 no status in data window", ns, 0);
    chk_eq("R1 no warning with clock low", nw, 0);
  endtask

  task automatic t_drop_high();
    clear_log();
    cs = 1'b1; wait_n(8);
    send_bit(1'b1, 1'b1);
    si = 1'b0; wait_n(4);
    sk = 1'b1; wait_n(8);
    cs = 1'b0; wait_n(4);
    sk = 1'b0; wait_n(12);
    chk_eq("R4 open bit dropped with clock high", nb, 1);
    chk_eq("R4 remaining bit span", b_dur[0], 16);
  endtask

  task automatic t_sk_high();
    clear_log();
    sk = 1'b1; wait_n(6);
    cs = 1'b1; wait_n(6);
    sk = 1'b0; wait_n(4);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    cs = 1'b0; wait_n(12);
    chk_eq("R1 one warning", nw, 1);
    chk_eq("R1 warning code clock high", w_code[0], 1);
    chk_eq("R1 bits after warning", nb, 2);
    chk_eq("R3 start flag after warning", b_first[0], 1);
    chk_eq("R2 so of second bit", b_so[1], 1);
  endtask

  task automatic t_poll_noclk();
    clear_log();
    so = 1'b0; wait_n(4);
    cs = 1'b1; wait_n(10);
    so = 1'b1; wait_n(20);
    cs = 1'b0; wait_n(12);
    so = 1'b0; wait_n(4);
    chk_eq("R5 no bits without clock", nb, 0);
    chk_eq("R6 two intervals", ns, 2);
    chk_eq("R6 first busy", s_rdy[0], 0);
    chk_eq("R6 busy span", s_t1[0] - s_t0[0], 10);
    chk_eq("R6 second ready", s_rdy[1], 1);
    chk_eq("R6 ready span to select fall", s_t1[1] - s_t0[1], 20);
    chk_eq("R6 intervals contiguous", s_t0[1], s_t1[0]);
  endtask

  task automatic t_poll_silow();
    clear_log();
    cs = 1'b1; wait_n(6);
    si = 1'b0; sk = 1'b1; wait_n(4);
    sk = 1'b0; wait_n(4);
    so = 1'b1; wait_n(6);
    cs = 1'b0; wait_n(12);
    so = 1'b0; wait_n(4);
    chk_eq("R5 no bits with input low at first rise", nb, 0);
    chk_eq("R6 interval count", ns, 2);
    chk_eq("R6 busy span", s_t1[0] - s_t0[0], 14);
    chk_eq("R6 ready span", s_t1[1] - s_t0[1], 6);
  endtask

  task automatic t_discard();
    clear_log();
    cs = 1'b1; wait_n(4);
    so = 1'b1; wait_n(4);
    so = 1'b0; wait_n(4);
    si = 1'b1; wait_n(2);
    sk = 1'b1; wait_n(8);
    sk = 1'b0; wait_n(4);
    cs = 1'b0; wait_n(12);
    chk_eq("R7 pending intervals discarded", ns, 0);
    chk_eq("R7 data bit still reported", nb, 1);
    chk_eq("R3 lone bit is start bit", b_first[0], 1);
  endtask

  task automatic t_overflow();
    clear_log();
    so = 1'b0; si = 1'b0;
    cs = 1'b1; wait_n(5);
    for (int i = 0; i < 6; i++) begin
      so = ~so; wait_n(5);
    end
    wait_n(2);
    cs = 1'b0; wait_n(16);
    chk_eq("R8 one overflow warning", nw, 1);
    chk_eq("R8 warning code overflow", w_code[0], 2);
    chk_eq("R8 stored plus final", ns, DEPTH + 1);
    chk_eq("R6 order of levels", s_rdy[0]*8 + s_rdy[1]*4 + s_rdy[2]*2 + s_rdy[3], 5);
    chk_eq("R8 stored span", s_t1[3] - s_t0[3], 5);
    chk_eq("R8 final level busy", s_rdy[DEPTH], 0);
    chk_eq("R8 final span", s_t1[DEPTH] - s_t0[DEPTH], 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    t_reset();
    t_data();
    t_drop_high();
    t_sk_high();
    t_poll_noclk();
    t_poll_silow();
    t_discard();
    t_overflow();
    done = 1'b1;
    report();
    $finish;
  end
endmodule